// File: doc/BRIEF.md
# Video Sync and Blanking Code Inserter

This block sits between a pixel demultiplexer and three 10-bit converter channels: one luma or green channel and two chroma or blue/red channels. On every rising clock edge it samples an active-low sync request, an active-low blanking request and an active-high control that picks the sync polarity. From these it registers, for each channel, either the incoming pixel code, the channel's blanking code, or a sync indication. Each channel output carries a 10-bit code and a two-bit level flag. While a channel shows sync, its code is held at its blanking code, so a later converter model only has to add the sync offset that the flag selects.

A single shared configuration pin sets two stored bits. The pin is sampled on the second rising edge after the sampled sync request changes. If the change was from low to high, the pin value is stored as the mode bit. If the change was from high to low, it is stored as the all-channel sync bit. The all-channel sync bit decides whether sync is applied to all three channels or only to luma. A status output shows whether the mode bit has been loaded since reset. A compile-time parameter selects a variant in which the chroma blanking code drops to 0 while sync is applied to luma only.

Top module: `vsync_inserter`

## Requirements
- R1: Outputs are registered one rising edge after the inputs are sampled. When sync request `syncN` and blank request `blankN` were both sampled high, each channel outputs its own sampled pixel code with level flag 2'b00 (data).
- R2: A sampled `syncN` low produces sync on luma whatever the value of `blankN`. Sync has priority over blanking.
- R3: During sync, the level flag is 2'b11 (positive) if `syncHi` was sampled high and 2'b10 (negative) if it was sampled low. The channel's code equals its blanking code. Holding `syncN` low while `syncHi` changes from low to high gives a tri-level sync: a negative phase followed by a positive phase.
- R4: While `syncN` is sampled high, `syncHi` has no effect on any output.
- R5: With `allChBit` high, sync applies to all three channels. With it low, only luma shows sync, and chroma follows `blankN` (blank or data).
- R6: A transition is a sampled `syncN` that differs from the previous sample. The sample of `syncN` taken before reset is treated as high. `cfgPin` is captured on the second rising edge after the transition edge. After a rising transition it goes to `modeBit`; after a falling transition it goes to `allChBit`. A new transition before the capture restarts the count and takes on the new direction. `modeBit` and `allChBit` change on no other edge.
- R7: With `syncN` sampled high and `blankN` sampled low, every channel shows level flag 2'b01 (blank). The luma code is 0 and the chroma code is 512.
- R8: With parameter `CHROMA_ZERO_Y_ONLY`=1 and `allChBit` low, the chroma blanking code is 0 instead of 512. This code is used for blank and for the code during chroma sync.
- R9: Reset sets every channel to the blank level with its blanking code, and clears `modeBit`, `allChBit` and `cfgValid`. `cfgValid` sets at the first `modeBit` capture and then stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncN | input | 1 | Sync request, active low |
| blankN | input | 1 | Blanking request, active low |
| syncHi | input | 1 | Sync polarity: high gives positive sync |
| cfgPin | input | 1 | Shared configuration pin |
| pixY | input | 10 | Luma / green pixel code |
| pixB | input | 10 | Pb / blue pixel code |
| pixR | input | 10 | Pr / red pixel code |
| codeY | output | 10 | Luma channel code |
| codeB | output | 10 | Pb / blue channel code |
| codeR | output | 10 | Pr / red channel code |
| lvlY | output | 2 | Luma level flag |
| lvlB | output | 2 | Pb / blue level flag |
| lvlR | output | 2 | Pr / red level flag |
| modeBit | output | 1 | Stored mode bit |
| allChBit | output | 1 | Stored all-channel sync bit |
| cfgValid | output | 1 | Mode bit loaded since reset |

## Verification
If the edge detector or capture counter is wrong, the stored bits go wrong at once. That appears on `modeBit` or `allChBit` one edge early or late, or after a restart that should have dropped the capture. Within the next sync interval the chroma level flags then switch between sync and blank or data. A wrong priority or polarity choice shows on the very next registered output as a wrong level flag. A wrong blanking code shows the same way as a wrong code. The bench tracks the stored bits every cycle, so a wrong capture is reported on the edge where it happens.

// File: rtl/vsi_pkg.sv
package vsi_pkg;

  typedef enum logic [1:0] {
    LVL_DATA     = 2'b00,
    LVL_BLANK    = 2'b01,
    LVL_SYNC_NEG = 2'b10,
    LVL_SYNC_POS = 2'b11
  } lvl_e;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic syncAct;     // sync requested this edge
    logic syncPos;     // positive phase
    logic blankAct;    // blank requested this edge
    logic syncAll;     // sync applies to chroma too
    logic chromaZero;  // chroma blanking code forced to zero
  } strobe_t;

endpackage

// File: rtl/vsi_ctrl.sv
module vsi_ctrl
  import vsi_pkg::*;
#(
  parameter bit CHROMA_ZERO_Y_ONLY = 1'b0,
  parameter int CAPTURE_DELAY      = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncN,
  input  logic    blankN,
  input  logic    syncHi,
  input  logic    cfgPin,
  output strobe_t stb,
  output logic    modeBit,
  output logic    allChBit,
  output logic    cfgValid
);

  localparam int CW = $clog2(CAPTURE_DELAY + 1);
  localparam logic [CW-1:0] CNT_FIRE = CW'(CAPTURE_DELAY);
  localparam logic [CW-1:0] CNT_IDLE = '0;
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          syncPrevQ;
  logic [CW-1:0] cntQ;
  logic          dirRiseQ;
  logic          syncEdge;
  logic          fire;

  assign syncEdge = (syncN != syncPrevQ);
  assign fire     = (cntQ == CNT_FIRE);

  always_comb begin
    stb.syncAct    = ~syncN;
    stb.syncPos    = ~syncN & syncHi;
    stb.blankAct   = ~blankN;
    stb.syncAll    = allChBit;
    stb.chromaZero = CHROMA_ZERO_Y_ONLY & ~allChBit;
  end

  // edge tracking and capture countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrevQ <= 1'b1;
      cntQ      <= CNT_IDLE;
      dirRiseQ  <= 1'b0;
    end else begin
      syncPrevQ <= syncN;
      if (syncEdge) begin
        cntQ     <= CNT_ONE;
        dirRiseQ <= syncN;
      end else if (fire) begin
        cntQ <= CNT_IDLE;
      end else if (cntQ != CNT_IDLE) begin
        cntQ <= cntQ + CNT_ONE;
      end
    end
  end

  // stored configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBit  <= 1'b0;
      allChBit <= 1'b0;
      cfgValid <= 1'b0;
    end else if (fire) begin
      if (dirRiseQ) begin
        modeBit  <= cfgPin;
        cfgValid <= 1'b1;
      end else begin
        allChBit <= cfgPin;
      end
    end
  end

  AST_CFG_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> ($stable(modeBit) && $stable(allChBit))); // R6
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid); // R9
  AST_VALID_FROM_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgValid) |-> $past(fire && dirRiseQ)); // R6

endmodule

// File: rtl/vsi_datapath.sv
module vsi_datapath
  import vsi_pkg::*;
#(
  parameter int NUM_CH             = 3,
  parameter int W                  = 10,
  parameter bit CHROMA_ZERO_Y_ONLY = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [NUM_CH-1:0][W-1:0] pixIn,
  output logic [NUM_CH-1:0][W-1:0] codeOut,
  output logic [NUM_CH-1:0][1:0]   lvlOut
);

  localparam logic [W-1:0] CODE_ZERO = '0;
  localparam logic [W-1:0] CODE_MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] CHROMA_RST = CHROMA_ZERO_Y_ONLY ? CODE_ZERO : CODE_MID;

  logic liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam bit IS_LUMA = (ch == 0);
    logic [W-1:0] blankCode;
    logic         syncHere;
    logic [W-1:0] codeNext;
    lvl_e         lvlNext;

    always_comb begin
      if (IS_LUMA)             blankCode = CODE_ZERO;
      else if (stb.chromaZero) blankCode = CODE_ZERO;
      else                     blankCode = CODE_MID;
      syncHere = stb.syncAct & (IS_LUMA | stb.syncAll);
      if (syncHere) begin
        lvlNext  = stb.syncPos ? LVL_SYNC_POS : LVL_SYNC_NEG;
        codeNext = blankCode;
      end else if (stb.blankAct) begin
        lvlNext  = LVL_BLANK;
        codeNext = blankCode;
      end else begin
        lvlNext  = LVL_DATA;
        codeNext = pixIn[ch];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeOut[ch] <= IS_LUMA ? CODE_ZERO : CHROMA_RST;
        lvlOut[ch]  <= LVL_BLANK;
      end else begin
        codeOut[ch] <= codeNext;
        lvlOut[ch]  <= lvlNext;
      end
    end
  end

  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && $past(stb.syncAct && stb.blankAct) |-> lvlOut[0][1]); // R2
  AST_SYNC_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && $past(stb.syncAct) |-> (lvlOut[0][0] == $past(stb.syncPos))); // R3
  AST_SYNC_LUMA_CODE: assert property (@(posedge clk) disable iff (!rstN)
    lvlOut[0][1] |-> (codeOut[0] == CODE_ZERO)); // R3
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && $past(!stb.syncAct && !stb.blankAct) |-> (codeOut[0] == $past(pixIn[0]))); // R1
  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && $past(!stb.syncAct && stb.blankAct) |-> (lvlOut == {NUM_CH{LVL_BLANK}})); // R7

endmodule

// File: rtl/vsync_inserter.sv
module vsync_inserter
  import vsi_pkg::*;
#(
  parameter int W                  = 10,
  parameter bit CHROMA_ZERO_Y_ONLY = 1'b0,
  parameter int CAPTURE_DELAY      = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncN,
  input  logic         blankN,
  input  logic         syncHi,
  input  logic         cfgPin,
  input  logic [W-1:0] pixY,
  input  logic [W-1:0] pixB,
  input  logic [W-1:0] pixR,
  output logic [W-1:0] codeY,
  output logic [W-1:0] codeB,
  output logic [W-1:0] codeR,
  output logic [1:0]   lvlY,
  output logic [1:0]   lvlB,
  output logic [1:0]   lvlR,
  output logic         modeBit,
  output logic         allChBit,
  output logic         cfgValid
);

  localparam int NUM_CH = 3;

  strobe_t                  stb;
  logic [NUM_CH-1:0][W-1:0] pixAll;
  logic [NUM_CH-1:0][W-1:0] codeAll;
  logic [NUM_CH-1:0][1:0]   lvlAll;

  assign pixAll = {pixR, pixB, pixY};

  vsi_ctrl #(
    .CHROMA_ZERO_Y_ONLY(CHROMA_ZERO_Y_ONLY),
    .CAPTURE_DELAY     (CAPTURE_DELAY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncN   (syncN),
    .blankN  (blankN),
    .syncHi  (syncHi),
    .cfgPin  (cfgPin),
    .stb     (stb),
    .modeBit (modeBit),
    .allChBit(allChBit),
    .cfgValid(cfgValid)
  );

  vsi_datapath #(
    .NUM_CH            (NUM_CH),
    .W                 (W),
    .CHROMA_ZERO_Y_ONLY(CHROMA_ZERO_Y_ONLY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .pixIn  (pixAll),
    .codeOut(codeAll),
    .lvlOut (lvlAll)
  );

  assign codeY = codeAll[0];
  assign codeB = codeAll[1];
  assign codeR = codeAll[2];
  assign lvlY  = lvlAll[0];
  assign lvlB  = lvlAll[1];
  assign lvlR  = lvlAll[2];

endmodule

// File: tb/tb_vsync_inserter.sv
module tb_vsync_inserter;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, syncN, blankN, syncHi, cfgPin;
  logic [9:0] pixY, pixB, pixR;
  logic [9:0] codeY, codeB, codeR, zCodeY, zCodeB, zCodeR;
  logic [1:0] lvlY, lvlB, lvlR, zLvlY, zLvlB, zLvlR;
  logic       modeBit, allChBit, cfgValid, zMode, zAll, zValid;

  vsync_inserter dut (
    .clk(clk), .rstN(rstN), .syncN(syncN), .blankN(blankN), .syncHi(syncHi),
    .cfgPin(cfgPin), .pixY(pixY), .pixB(pixB), .pixR(pixR),
    .codeY(codeY), .codeB(codeB), .codeR(codeR),
    .lvlY(lvlY), .lvlB(lvlB), .lvlR(lvlR),
    .modeBit(modeBit), .allChBit(allChBit), .cfgValid(cfgValid));

  vsync_inserter #(.CHROMA_ZERO_Y_ONLY(1'b1)) dutZ (
    .clk(clk), .rstN(rstN), .syncN(syncN), .blankN(blankN), .syncHi(syncHi),
    .cfgPin(cfgPin), .pixY(pixY), .pixB(pixB), .pixR(pixR),
    .codeY(zCodeY), .codeB(zCodeB), .codeR(zCodeR),
    .lvlY(zLvlY), .lvlB(zLvlB), .lvlR(zLvlR),
    .modeBit(zMode), .allChBit(zAll), .cfgValid(zValid));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model of the stored configuration
  logic mPrev, mDir, mMode, mAll, mValid;
  int   mCnt;

  function automatic logic [11:0] expCh(int ch, logic sy, logic bl, logic th,
                                        logic [9:0] px, logic allC, logic zv);
    logic [9:0] bc;
    bc = (ch == 0) ? 10'd0 : ((zv && !allC) ? 10'd0 : 10'd512);
    if (!sy && (ch == 0 || allC)) return {(th ? 2'b11 : 2'b10), bc};
    if (!bl) return {2'b01, bc};
    return {2'b00, px};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic sy, logic bl, logic th, logic cf, string tag);
    logic [11:0] eY, eB, eR, zB, zR;
    logic [9:0] py, pb, pr;
    py = 10'($urandom); pb = 10'($urandom); pr = 10'($urandom);
    @(negedge clk);
    syncN = sy; blankN = bl; syncHi = th; cfgPin = cf;
    pixY = py; pixB = pb; pixR = pr;
    eY = expCh(0, sy, bl, th, py, mAll, 1'b0);
    eB = expCh(1, sy, bl, th, pb, mAll, 1'b0);
    eR = expCh(2, sy, bl, th, pr, mAll, 1'b0);
    zB = expCh(1, sy, bl, th, pb, mAll, 1'b1);
    zR = expCh(2, sy, bl, th, pr, mAll, 1'b1);
    @(posedge clk);
    #1;
    // model update at this edge
    if (mCnt == 2) begin
      if (mDir) begin mMode = cf; mValid = 1'b1; end
      else mAll = cf;
    end
    if (sy != mPrev) begin mCnt = 1; mDir = sy; end
    else if (mCnt == 2) mCnt = 0;
    else if (mCnt == 1) mCnt = 2;
    mPrev = sy;
    chk(tag, {8'd0, lvlY, codeY, lvlB, codeB}, {8'd0, eY, eB});
    chk(tag, {20'd0, lvlR, codeR}, {20'd0, eR});
    chk({tag, " R8 variant"}, {8'd0, zLvlB, zCodeB, zLvlR, zCodeR}, {8'd0, zB, zR});
    chk({tag, " R6 cfg"}, {29'd0, modeBit, allChBit, cfgValid}, {29'd0, mMode, mAll, mValid});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic sy, bl, th, cf;
    process::self().srandom(32'd7031);
    rstN = 1'b0; syncN = 1'b1; blankN = 1'b1; syncHi = 1'b0; cfgPin = 1'b0;
    pixY = '0; pixB = '0; pixR = '0;
    mPrev = 1'b1; mDir = 1'b0; mMode = 1'b0; mAll = 1'b0; mValid = 1'b0; mCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset main", {lvlY, codeY, lvlB, codeB, lvlR, codeR},
        {2'b01, 10'd0, 2'b01, 10'd512, 2'b01, 10'd512});
    chk("R9 reset variant", {zLvlB, zCodeB, zLvlR, zCodeR}, {2'b01, 10'd0, 2'b01, 10'd0});
    chk("R9 reset cfg", {modeBit, allChBit, cfgValid}, 3'b000);
    rstN = 1'b1;

    // R1 data pass-through
    repeat (4) step(1, 1, 0, 0, "R1 data");
    // R7 blanking
    repeat (3) step(1, 0, 0, 0, "R7 blank");
    // R4 syncHi ignored while sync inactive
    step(1, 1, 1, 0, "R4 ignore");
    step(1, 0, 1, 0, "R4 ignore blank");
    step(1, 1, 0, 0, "R4 ignore");
    // R2/R3 luma-only sync, negative then positive (tri-level) over blank
    step(0, 0, 0, 0, "R2 sync over blank");
    step(0, 1, 0, 0, "R5 luma only");
    step(0, 0, 0, 1, "R6 capture allCh");   // falling edge + 2: allChBit <- 1
    step(0, 0, 1, 1, "R3 tri-level pos");
    step(1, 1, 0, 0, "R1 data");
    step(1, 1, 0, 0, "R1 data");
    step(1, 0, 0, 1, "R6 capture mode");    // rising edge + 2: modeBit <- 1
    // R5 all-channel sync, tri-level
    step(0, 0, 0, 0, "R5 all neg");
    step(0, 1, 0, 0, "R5 all neg");
    step(0, 1, 0, 1, "R5 all neg keep");
    step(0, 1, 1, 1, "R3 all pos");
    step(0, 0, 1, 1, "R3 all pos");
    // R6 restart: falling then rising before capture
    step(1, 1, 0, 0, "R6 restart");
    step(0, 1, 0, 0, "R6 restart");
    step(1, 1, 0, 0, "R6 restart");
    step(1, 1, 0, 1, "R6 restart");
    step(1, 1, 0, 0, "R6 restart");
    // clear allCh and check R8 variant
    step(0, 1, 0, 1, "R6 fall");
    step(0, 1, 0, 0, "R6 fall");
    step(0, 1, 0, 0, "R6 clear allCh");
    step(0, 0, 1, 0, "R8 luma sync chroma blank");
    step(1, 0, 0, 0, "R8 blank zero chroma");

    // constrained random: long sync/blank runs
    sy = 1'b1; bl = 1'b1; th = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 6) == 0) sy = ~sy;
      if (($urandom % 5) == 0) bl = ~bl;
      if (($urandom % 4) == 0) th = ~th;
      cf = 1'($urandom);
      step(sy, bl, th, cf, !sy ? "R3 rnd sync" : (!bl ? "R7 rnd blank" : "R1 rnd data"));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule